// File: doc/BRIEF.md
# Interrupt Main Status Register

This block is the main status byte of a timekeeping controller's register file. A host reaches it over a plain byte-wide read/write bus. It always answers at offset 0, whatever bank the rest of the address space is switched to. Reading it shows three things. The first is a live summary of whether either interrupt output is asserted. The second is three latched interrupt causes, each fed by an internal event strobe. The third is four bits of host-owned storage, one of which is the bank-select value that the rest of the register file decodes.

The three cause bits do not share one clear rule. The two upper causes clear only when the host writes a one to their own bit position. The lowest cause ignores the bus completely and is held clear for as long as the power-fail input is high. No read ever disturbs a cause, so the host can poll the byte safely. Masking, interrupt generation and the event counters live outside the block and arrive as plain inputs.

Top module: `msr_main_status`

## Requirements
- R1: The register is written and read only when the address equals 0, and this holds for either value of `bank_sel`. A write at any other address changes nothing, and a read at any other address returns 8'h00 on `rdata`.
- R2: `rdata[0]` reads the live OR of `irq_a` and `irq_b` in the same cycle, and no write value affects it.
- R3: Reading the register never clears or changes any of bits 1 to 3.
- R4: Bits 2 and 3 clear on the clock edge of a write at address 0 that carries a one in that bit position. A zero in that position leaves the bit unchanged.
- R5: Bit 1 ignores all written values. It is 0 after every clock edge at which `pwr_fail` is 1, even if its event strobe is high in that cycle.
- R6: A high `evt[0]`, `evt[1]` or `evt[2]` sets bit 1, 2 or 3 respectively at the next clock edge. For bits 2 and 3 the event wins over a write-one clear made in the same cycle.
- R7: Bit 6 is read/write, and its stored value drives `bank_sel`.
- R8: Bits 4, 5 and 7 are read/write storage that returns the last value written at address 0.
- R9: A synchronous active-low reset clears all stored bits to 0, which also drives `bank_sel` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (5) | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq_a | input | 1 | First interrupt output level |
| irq_b | input | 1 | Second interrupt output level |
| evt | input | 3 | Event strobes for cause bits 1, 2, 3 |
| pwr_fail | input | 1 | Power-fail level |
| bank_sel | output | 1 | Bank-select value (bit 6) |

## Verification
Each cause bit is driven through every combination of its prior state, its event strobe and its clear condition. For bits 2 and 3 the clear condition is a write-one; for bit 1 it is the power-fail level together with a write. This separates event-beats-clear from clear-beats-event and shows that a write to bit 1 does nothing. All 256 write values go to offset 0 to separate storage bits from read-only positions. Writes to every other offset, made with either bank selected, show that the decode does not depend on the bank. All four interrupt-level pairs check the live summary bit.

// File: rtl/msr_pkg.sv
// Package: shared widths and bit positions of the main status byte.
// Assumes a byte-wide data bus; bit positions are fixed because the
// bank decode elsewhere reads bit 6.
package msr_pkg;
    localparam int DATA_W    = 8;
    localparam int CAUSE_LO  = 1;
    localparam int CAUSE_N   = 3;
    localparam int STORE_LO  = 4;
    localparam int STORE_N   = 4;
    localparam int BANK_BIT  = 6;
    localparam int BANK_IDX  = BANK_BIT - STORE_LO;

    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/msr_bus_decode.sv
// Module: address decode for the main status byte.
// Produces read and write hits for offset 0 only. It assumes no bank
// input is needed, because this byte is visible in every bank.
module msr_bus_decode #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] MSR_OFFSET = '0;

    logic sel;

    // Offset compare shared by both strobes.
    always_comb begin
        sel    = (addr == MSR_OFFSET);
        wr_hit = wr_en && sel;
        rd_hit = rd_en && sel;
    end

    // R1: a hit is only ever produced at offset 0.
    p_hit_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit || rd_hit) |-> (addr == '0));
endmodule

// File: rtl/msr_cause_bit.sv
// Module: one latched interrupt cause.
// Set by a one-cycle event strobe and cleared by a clear request. The
// parameter CLEAR_WINS picks the priority between them: a level clear
// dominates, a write-one clear yields to the event. Reads do not touch it.
module msr_cause_bit #(
    parameter bit CLEAR_WINS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic q
);
    logic nxt;

    // Next-state choice according to the selected priority.
    generate
        if (CLEAR_WINS) begin : g_level_clear
            always_comb nxt = clr ? 1'b0 : (q | evt);
        end else begin : g_event_first
            always_comb nxt = evt | (q & ~clr);
        end
    endgenerate

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

    // R6: an event sets the bit unless a dominant clear is present.
    p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !(CLEAR_WINS && clr)) |=> q);

    // R5/R4: a clear without a competing event always empties the bit.
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (CLEAR_WINS || !evt)) |=> !q);

    // R3: without an event or a clear the bit holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(q));
endmodule

// File: rtl/msr_store.sv
// Module: host-owned read/write bits of the status byte.
// Loads on a write hit and otherwise holds. It assumes the caller slices
// out only the storage field of the write data.
module msr_store #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Storage register, loaded by a write at offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_hit) q <= d;
    end

    // R8: a write lands exactly the written field.
    p_store_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (q == $past(d)));

    // R8: no write, no change.
    p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(q));
endmodule

// File: rtl/msr_main_status.sv
// Module: main status byte of a timekeeping controller (top).
// Bit 0 shows the live interrupt summary, bits 1..3 hold latched causes,
// and bits 4..7 are storage, with bit 6 exported as the bank select.
// It assumes the event strobes are synchronous one-cycle pulses and that
// pwr_fail is already synchronised to clk.
module msr_main_status
    import msr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              irq_a,
    input  logic              irq_b,
    input  logic [CAUSE_N-1:0] evt,
    input  logic              pwr_fail,
    output logic              bank_sel
);
    logic               wr_hit;
    logic               rd_hit;
    logic [CAUSE_N-1:0] cause;
    logic [CAUSE_N-1:0] cause_clr;
    logic [STORE_N-1:0] store_q;
    logic               pend;
    logic               unused_wbit0;
    byte_t              status;

    assign unused_wbit0 = wdata[0];

    msr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    // Cause bits: the lowest uses the power-fail level, the others write-one.
    generate
        for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
            if (i == 0) begin : g_pf
                assign cause_clr[i] = pwr_fail;
            end else begin : g_w1c
                assign cause_clr[i] = wr_hit & wdata[CAUSE_LO+i];
            end
            msr_cause_bit #(.CLEAR_WINS(i == 0)) u_cause (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt[i]),
                .clr   (cause_clr[i]),
                .q     (cause[i])
            );
        end
    endgenerate

    msr_store #(.N(STORE_N)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .d      (wdata[STORE_LO +: STORE_N]),
        .q      (store_q)
    );

    // Assemble the status byte and gate it onto the read port.
    always_comb begin
        pend   = irq_a | irq_b;
        status = {store_q, cause, pend};
        rdata  = rd_hit ? status : '0;
    end

    assign bank_sel = store_q[BANK_IDX];

    // R2: summary bit tracks the interrupt levels on every offset-0 read.
    always_comb begin
        if (rst_n && rd_hit)
            p_live_pend_r2: assert (rdata[0] == (irq_a | irq_b));
    end

    // R5: bit 1 reads 0 after any edge with power-fail high.
    p_pf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (cause[0] == 1'b0));

    // R5: a write alone never lowers bit 1.
    p_bit1_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !pwr_fail && cause[0]) |=> cause[0]);

    // R7: bank select follows bit 6 of an offset-0 write.
    p_bank_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (bank_sel == $past(wdata[BANK_BIT])));

    // R1: reads away from offset 0 return zero.
    p_off_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != '0) |-> (rdata == '0));

    // R9: reset leaves the bank select low.
    p_reset_bank_r9: assert property (@(posedge clk)
        !rst_n |=> !bank_sel);
endmodule

// File: tb/sim_msr_main_status.sv
module sim_msr_main_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_a = 1'b0;
    logic       irq_b = 1'b0;
    logic [2:0] evt = '0;
    logic       pwr_fail = 1'b0;
    logic       bank_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    msr_main_status u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b),
        .evt(evt), .pwr_fail(pwr_fail), .bank_sel(bank_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clocked cycle with the given bus/event stimulus, then idle.
    task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d,
                       input logic [2:0] e, input logic pf);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; evt = e; pwr_fail = pf;
        @(posedge clk);
        #1;
        wr_en = 1'b0; addr = '0; wdata = '0; evt = '0; pwr_fail = 1'b0;
    endtask

    // Combinational read at an offset, sampled mid-cycle.
    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #5;
        v = rdata;
        rd_en = 1'b0; addr = '0;
    endtask

    initial begin
        logic [7:0] v;
        logic exp1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(5'd0, v);
        check("R9 reset value", v, 8'h00);
        check("R9 reset bank", {7'd0, bank_sel}, 8'h00);

        // R8/R7: all write values at offset 0.
        for (int w = 0; w < 256; w++) begin
            cyc(1'b1, 5'd0, w[7:0], 3'b000, 1'b0);
            rd(5'd0, v);
            check("R8 storage", v, w[7:0] & 8'hF0);
            check("R7 bank", {7'd0, bank_sel}, {7'd0, w[6]});
        end

        // R1: writes elsewhere ignored in both banks; reads elsewhere zero.
        for (int b = 0; b < 2; b++) begin
            cyc(1'b1, 5'd0, {1'b1, b[0], 6'b010000}, 3'b000, 1'b0);
            for (int a = 1; a < 32; a++) begin
                cyc(1'b1, a[4:0], 8'h00, 3'b000, 1'b0);
                rd(a[4:0], v);
                check("R1 off-offset read", v, 8'h00);
            end
            rd(5'd0, v);
            check("R1 offset 0 intact", v, {1'b1, b[0], 6'b010000});
        end

        // R2: live summary under all level pairs, write to bit 0 ignored.
        cyc(1'b1, 5'd0, 8'h01, 3'b000, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            irq_a = k[0]; irq_b = k[1];
            rd(5'd0, v);
            check("R2 pending", {7'd0, v[0]}, {7'd0, k[0] | k[1]});
        end
        irq_a = 1'b0; irq_b = 1'b0;

        // R4/R6: bits 2 and 3, sweep prior state x event x write-one.
        for (int bit_i = 2; bit_i <= 3; bit_i++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] m;
                logic [2:0] ev;
                m = 8'h01 << bit_i;
                ev = 3'b001 << (bit_i - 1);
                cyc(1'b1, 5'd0, m, 3'b000, 1'b0);
                if (c[0]) cyc(1'b0, 5'd0, 8'h00, ev, 1'b0);
                cyc(1'b1, 5'd0, c[2] ? m : 8'h00, c[1] ? ev : 3'b000, 1'b0);
                rd(5'd0, v);
                exp1 = c[1] | (c[0] & ~c[2]);
                check(bit_i == 2 ? "R4/R6 bit2" : "R4/R6 bit3",
                      {7'd0, v[bit_i]}, {7'd0, exp1});
            end
        end

        // R5/R6: bit 1, sweep prior state x event x power-fail x write.
        for (int c = 0; c < 16; c++) begin
            cyc(1'b0, 5'd0, 8'h00, 3'b000, 1'b1);
            if (c[0]) cyc(1'b0, 5'd0, 8'h00, 3'b001, 1'b0);
            cyc(c[3], 5'd0, c[3] ? 8'h02 : 8'h00, {2'b00, c[1]}, c[2]);
            rd(5'd0, v);
            exp1 = c[2] ? 1'b0 : (c[0] | c[1]);
            check("R5/R6 bit1", {7'd0, v[1]}, {7'd0, exp1});
        end

        // R3: reads do not clear causes.
        cyc(1'b1, 5'd0, 8'h00, 3'b111, 1'b0);
        for (int k = 0; k < 3; k++) begin
            rd(5'd0, v);
            check("R3 read keeps causes", v & 8'h0E, 8'h0E);
        end

        // R9: reset from a populated state.
        cyc(1'b1, 5'd0, 8'hF0, 3'b111, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk) rst_n = 1'b1;
        rd(5'd0, v);
        check("R9 reset clears", v, 8'h00);
        check("R9 reset bank", {7'd0, bank_sel}, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule